// File: doc/BRIEF.md
# Memory Channel Event Counter Unit

This block counts hardware events for one memory controller channel. Eight 32-bit counters each count one event line. The event-to-counter tie is fixed, and no selection field exists. In index order the events are: bytes written, bytes read, write commands, read commands, precharge commands, activate commands, rank switches and read/write direction turnarounds. Each event line is a one-cycle pulse, and each pulse adds one to its counter.

Software reaches the block through a simple 32-bit register bus. The bus gives access to:
- a global run bit;
- a per-counter enable mask;
- an interrupt mask;
- a sticky overflow status word;
- a write-one-to-clear register;
- the counters themselves.

Software can preload a counter to set a sampling period. When a counter wraps, its status flag is set. The level interrupt output is high while any status flag is set whose mask bit is 0.

Top module: `mcu_evt_counter_unit`

## Requirements
- R1: After reset all counters read 0, the control word and the enable mask read 0, the interrupt mask reads 0x000000FF, the status reads 0 and `irq_out` is low.
- R2: Counter k sits at one of these byte addresses: k=0 at 0x380, 1 at 0x384, 2 at 0x388, 3 at 0x38C, 4 at 0x3C0, 5 at 0x3C4, 6 at 0x3CC, 7 at 0x3D0. A read returns its value in the same cycle. A write loads all 32 bits at the next clock edge.
- R3: Counter k adds one on each clock edge where `evt_in[k]` is 1, the global run bit is 1 and enable bit k is 1. In every other cycle it holds its value.
- R4: The global run bit is bit 1 of the control word at 0x010. No counter changes while it is 0. The other bits of the control word read 0.
- R5: The per-counter enable mask is at 0x6C0, and bit k gates counter k.
- R6: A counter at 0xFFFFFFFF that counts goes to 0, and its status bit k is set on that same edge.
- R7: A bus write to a counter on the same edge as its event loads the written value. No increment and no overflow happen.
- R8: The status word at 0x6CC holds flag k in bit k. Each flag stays set until cleared, whether or not it is masked. Bus writes to 0x6CC do nothing.
- R9: Writing 1 to bit k of 0x6D0 clears status bit k, and writing 0 leaves that bit as it is. If an overflow and a clear of the same bit fall on the same edge, the bit ends up set. Address 0x6D0 reads 0.
- R10: The interrupt mask at 0x6C8 has one bit per counter, where 1 blocks the interrupt. `irq_out` is 1 exactly when some status bit k is 1 and mask bit k is 0.
- R11: An address that matches no register exactly reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 8 | One-cycle event pulses, bit k feeds counter k |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read; 0 when idle |
| irq_out | output | 1 | Level interrupt |

## Verification
Reads are combinational, so a read result is due in the cycle its address is presented. The bench drives the address at the falling edge and samples the result one time step later. Writes, counts, overflows and clears each take effect at the first rising edge after they are presented. Status and `irq_out` follow that same edge with no further register stage. Every bench task therefore drives its stimulus at a falling edge and lets exactly the intended number of rising edges pass. It then reads back at the next falling edge. The collision cases put a bus write and an event pulse on the same rising edge. These are a load against a count, and a clear against an overflow.

// File: rtl/mcu_evt_pkg.sv
package mcu_evt_pkg;
  localparam int NUM_CNT = 8;
  localparam int CNT_W   = 32;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = $clog2(NUM_CNT);

  localparam logic [ADDR_W-1:0] A_CTRL  = 12'h010;
  localparam logic [ADDR_W-1:0] A_ENAB  = 12'h6C0;
  localparam logic [ADDR_W-1:0] A_MASK  = 12'h6C8;
  localparam logic [ADDR_W-1:0] A_STAT  = 12'h6CC;
  localparam logic [ADDR_W-1:0] A_CLEAR = 12'h6D0;
  localparam int RUN_BIT = 1;

  typedef enum logic [2:0] {
    RD_NONE, RD_CNT, RD_CTRL, RD_ENAB, RD_MASK, RD_STAT
  } rd_kind_e;

  // address of counter k; the two groups are not contiguous
  function automatic logic [ADDR_W-1:0] cnt_offset(input int unsigned k);
    case (k)
      0: return 12'h380;
      1: return 12'h384;
      2: return 12'h388;
      3: return 12'h38C;
      4: return 12'h3C0;
      5: return 12'h3C4;
      6: return 12'h3CC;
      default: return 12'h3D0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] v);
    return v + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic cnt_at_top(input logic [CNT_W-1:0] v);
    return &v;
  endfunction
endpackage

// File: rtl/mcu_bus_decode.sv
module mcu_bus_decode
  import mcu_evt_pkg::*;
#(
  parameter int N  = NUM_CNT,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  output logic [N-1:0]  cnt_hit,
  output logic [N-1:0]  cnt_wr,
  output logic          ctrl_wr,
  output logic          enab_wr,
  output logic          mask_wr,
  output logic          clear_wr,
  output rd_kind_e      rd_kind
);
  logic wr_go;
  logic any_cnt;

  assign wr_go = bus_en & bus_we;

  for (genvar k = 0; k < N; k++) begin : g_hit
    assign cnt_hit[k] = (bus_addr == cnt_offset(k));
    assign cnt_wr[k]  = wr_go & cnt_hit[k];
  end

  assign any_cnt  = |cnt_hit;
  assign ctrl_wr  = wr_go & (bus_addr == A_CTRL);
  assign enab_wr  = wr_go & (bus_addr == A_ENAB);
  assign mask_wr  = wr_go & (bus_addr == A_MASK);
  assign clear_wr = wr_go & (bus_addr == A_CLEAR);

  always_comb begin
    rd_kind = RD_NONE;
    if (bus_en && !bus_we) begin
      if (any_cnt)                    rd_kind = RD_CNT;
      else if (bus_addr == A_CTRL)    rd_kind = RD_CTRL;
      else if (bus_addr == A_ENAB)    rd_kind = RD_ENAB;
      else if (bus_addr == A_MASK)    rd_kind = RD_MASK;
      else if (bus_addr == A_STAT)    rd_kind = RD_STAT;
    end
  end

  // R2
  cnt_wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cnt_wr));
  // R11
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({|cnt_wr, ctrl_wr, enab_wr, mask_wr, clear_wr}) <= 1);
endmodule

// File: rtl/mcu_counter_slice.sv
module mcu_counter_slice
  import mcu_evt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_req,
  input  logic         load_req,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic         wrap_evt
);
  logic inc_go;

  // a bus load has priority over the event increment
  assign inc_go   = inc_req & ~load_req;
  assign wrap_evt = inc_go & cnt_at_top(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load_req) cnt_q <= load_val;
    else if (inc_go)   cnt_q <= cnt_step(cnt_q);
  end

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> cnt_q == $past(load_val));
  // R6
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> cnt_q == '0);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_req && !load_req) |=> $stable(cnt_q));
endmodule

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wrap_evt,
  input  logic         mask_wr,
  input  logic         clear_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] status_q,
  output logic [N-1:0] mask_q,
  output logic         irq_out
);
  logic [N-1:0] clr_bits;
  logic [N-1:0] live;

  assign clr_bits = clear_wr ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      // overflow is ORed after the clear so it wins a collision
      status_q <= (status_q & ~clr_bits) | wrap_evt;
      if (mask_wr) mask_q <= wbits;
    end
  end

  assign live    = status_q & ~mask_q;
  assign irq_out = |live;

  // R6
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |wrap_evt |=> (status_q & $past(wrap_evt)) == $past(wrap_evt));
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_wr |=> (status_q & $past(status_q)) == $past(status_q));
  // R9
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_wr && wrap_evt == '0) |=> (status_q & $past(wbits)) == '0);
  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq_out);
endmodule

// File: rtl/mcu_evt_counter_unit.sv
module mcu_evt_counter_unit
  import mcu_evt_pkg::*;
#(
  parameter int N  = NUM_CNT,
  parameter int W  = CNT_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt_in,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_out
);
  logic [N-1:0] cnt_hit, cnt_wr;
  logic         ctrl_wr, enab_wr, mask_wr, clear_wr;
  rd_kind_e     rd_kind;

  logic         run_q;
  logic [N-1:0] enab_q;
  logic [N-1:0] inc_req;
  logic [N-1:0] wrap_evt;
  logic [N-1:0] status_q, mask_q;
  logic [W-1:0] cnt_val [N];

  mcu_bus_decode #(.N(N), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .cnt_hit(cnt_hit), .cnt_wr(cnt_wr),
    .ctrl_wr(ctrl_wr), .enab_wr(enab_wr), .mask_wr(mask_wr),
    .clear_wr(clear_wr), .rd_kind(rd_kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      enab_q <= '0;
    end else begin
      if (ctrl_wr) run_q  <= bus_wdata[RUN_BIT];
      if (enab_wr) enab_q <= bus_wdata[N-1:0];
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_cnt
    assign inc_req[k] = run_q & enab_q[k] & evt_in[k];
    mcu_counter_slice #(.W(W)) u_slice (
      .clk(clk), .rst_n(rst_n), .inc_req(inc_req[k]),
      .load_req(cnt_wr[k]), .load_val(bus_wdata[W-1:0]),
      .cnt_q(cnt_val[k]), .wrap_evt(wrap_evt[k])
    );
  end

  mcu_irq_ctrl #(.N(N)) u_irq (
    .clk(clk), .rst_n(rst_n), .wrap_evt(wrap_evt), .mask_wr(mask_wr),
    .clear_wr(clear_wr), .wbits(bus_wdata[N-1:0]), .status_q(status_q),
    .mask_q(mask_q), .irq_out(irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    case (rd_kind)
      RD_CNT: begin
        for (int k = 0; k < N; k++)
          if (cnt_hit[k]) bus_rdata[W-1:0] = cnt_val[k];
      end
      RD_CTRL: bus_rdata[RUN_BIT] = run_q;
      RD_ENAB: bus_rdata[N-1:0]   = enab_q;
      RD_MASK: bus_rdata[N-1:0]   = mask_q;
      RD_STAT: bus_rdata[N-1:0]   = status_q;
      default: bus_rdata = '0;
    endcase
  end

  // R4
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> inc_req == '0);
  // R5
  enab_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req & ~enab_q) == '0);
  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> bus_rdata == '0);
endmodule

// File: tb/test_mcu_evt_counter_unit.sv
module test_mcu_evt_counter_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_in = '0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  localparam logic [11:0] CA [8] = '{12'h380, 12'h384, 12'h388, 12'h38C,
                                     12'h3C0, 12'h3C4, 12'h3CC, 12'h3D0};

  always #5 clk = ~clk;

  mcu_evt_counter_unit i_mcu_evt_counter_unit (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic cmp(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [7:0] ev);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; evt_in = ev;
    @(negedge clk);
    bus_en = 0; bus_we = 0; evt_in = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1;
    cmp(tag, bus_rdata, exp);
    bus_en = 0;
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    @(negedge clk); #1;
    cmp(tag, {31'b0, irq_out}, {31'b0, exp});
  endtask

  task automatic pulse(input logic [7:0] m, input int n);
    @(negedge clk);
    evt_in = m;
    repeat (n) @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset;
    for (int k = 0; k < 8; k++) rd_chk("R1 counter reset", CA[k], 0);
    rd_chk("R1 ctrl reset", 12'h010, 0);
    rd_chk("R1 enable reset", 12'h6C0, 0);
    rd_chk("R1 mask reset", 12'h6C8, 32'hFF);
    rd_chk("R1 status reset", 12'h6CC, 0);
    irq_chk("R1 irq reset", 0);
  endtask

  task automatic t_rw;
    for (int k = 0; k < 8; k++) wr(CA[k], 32'hA5000000 + k * 32'h01010101, 0);
    for (int k = 0; k < 8; k++) rd_chk("R2 counter readback", CA[k], 32'hA5000000 + k * 32'h01010101);
    for (int k = 0; k < 8; k++) wr(CA[k], 0, 0);
  endtask

  task automatic t_gating;
    wr(12'h6C0, 32'hFF, 0);
    rd_chk("R5 enable readback", 12'h6C0, 32'hFF);
    pulse(8'hFF, 5);
    rd_chk("R4 no count while run bit clear", CA[3], 0);
    wr(12'h010, 32'hFFFFFFFF, 0);
    rd_chk("R4 ctrl only bit 1", 12'h010, 32'h2);
    wr(12'h6C0, 32'h08, 0);
    pulse(8'hFF, 4);
    rd_chk("R5 enabled counter 3 counts", CA[3], 4);
    rd_chk("R5 disabled counter 4 holds", CA[4], 0);
    wr(12'h6C0, 32'hFF, 0);
    pulse(8'b1010_0101, 3);
    rd_chk("R3 pattern counter 0", CA[0], 3);
    rd_chk("R3 pattern counter 1", CA[1], 0);
    rd_chk("R3 pattern counter 7", CA[7], 3);
    rd_chk("R3 pattern counter 3", CA[3], 4);
  endtask

  task automatic t_overflow;
    wr(CA[0], 32'hFFFFFFFE, 0);
    pulse(8'h01, 1);
    rd_chk("R6 one below top", CA[0], 32'hFFFFFFFF);
    rd_chk("R6 no flag before wrap", 12'h6CC, 0);
    pulse(8'h01, 1);
    rd_chk("R6 wrapped to zero", CA[0], 0);
    rd_chk("R8 flag set while masked", 12'h6CC, 32'h01);
    irq_chk("R10 masked flag no irq", 0);
    wr(12'h6C8, 32'hFE, 0);
    irq_chk("R10 unmasked irq high", 1);
    wr(12'h6CC, 32'h00, 0);
    rd_chk("R8 status write ignored", 12'h6CC, 32'h01);
    wr(12'h6D0, 32'h00, 0);
    rd_chk("R9 write zero keeps flag", 12'h6CC, 32'h01);
    rd_chk("R9 clear reads zero", 12'h6D0, 0);
    wr(12'h6D0, 32'h01, 0);
    rd_chk("R9 clear one", 12'h6CC, 0);
    irq_chk("R10 irq drops", 0);
  endtask

  task automatic t_collide;
    wr(CA[1], 32'h100, 0);
    wr(CA[1], 32'h200, 8'h02);
    rd_chk("R7 load beats count", CA[1], 32'h200);
    wr(CA[2], 32'hFFFFFFFF, 8'h04);
    rd_chk("R7 load at top no wrap", CA[2], 32'hFFFFFFFF);
    rd_chk("R7 no flag on load", 12'h6CC, 0);
    wr(12'h6D0, 32'h04, 8'h04);
    rd_chk("R9 overflow beats clear", 12'h6CC, 32'h04);
    rd_chk("R9 counter wrapped", CA[2], 0);
    wr(12'h6C8, 32'hFB, 0);
    irq_chk("R10 irq for bit 2", 1);
    wr(12'h6D0, 32'hFF, 0);
    irq_chk("R10 irq cleared", 0);
  endtask

  task automatic t_unmapped;
    wr(12'h390, 32'hDEADBEEF, 0);
    wr(12'h381, 32'hDEADBEEF, 0);
    rd_chk("R11 unmapped read", 12'h390, 0);
    rd_chk("R11 misaligned read", 12'h381, 0);
    rd_chk("R11 counter 0 untouched", CA[0], 0);
    rd_chk("R11 counter 4 untouched", CA[4], 0);
    rd_chk("R11 status untouched", 12'h6CC, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rw();
    t_gating();
    t_overflow();
    t_collide();
    t_unmapped();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule